// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Error Queue

This block holds the two byte queues that sit between a UART serializer and the register bank. The receive side stores each incoming byte together with the four error flags the deserializer raised for it. The error flags of the oldest entry are always visible, so software sees the errors for a byte before it reads that byte. The transmit side is a plain byte queue. Each side compares its fill level against a programmable threshold and raises a service request. A status word packs both counts, both full flags and a pending-error flag.

The pending-error flag stays set while any stored receive entry still carries a nonzero error. Reading the error register clears the flags of the head entry, so the pending flag drops only once the last errored entry has been read or popped. A push into a full receive queue discards the byte and marks the newest stored entry with an overrun. When the queues are switched off, each side behaves as a single holding register.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each queue holds up to 16 entries. The status word carries the receive count modulo 16 in [3:0] and the transmit count modulo 16 in [7:4]. Bit 8 is receive full and bit 9 is transmit full, so a full queue shows a count field of 0 with its full bit set.
- R2: With the queues enabled, `rx_irq_o` is high exactly when the receive count is at least the level chosen by `rx_trig_i`: code 0 selects 4, code 1 selects 8, code 2 selects 12 and code 3 selects 16.
- R3: With the queues enabled, `tx_irq_o` is high exactly when the transmit count is at most the level chosen by `tx_trig_i`: code 0 selects 0 (empty), code 1 selects 4, code 2 selects 8 and code 3 selects 12.
- R4: With `fifo_en_i` low, each queue holds one entry and is full at a count of 1. `rx_irq_o` is high at a count of 1, and `tx_irq_o` is high only when the transmit queue is empty.
- R5: A one-cycle pulse on `rx_rst_i` or `tx_rst_i` empties that queue at the next clock edge. A push in the same cycle is discarded. A receive flush also clears the pending-error flag.
- R6: `rx_data_o` and `rx_err_o` show the byte and error flags of the oldest receive entry. The flags are encoded as bit 0 overrun, bit 1 parity, bit 2 frame and bit 3 break. `rx_err_o` is 0 when the queue is empty.
- R7: A receive push into a full queue with no pop in the same cycle leaves the count unchanged, discards the byte and sets the overrun bit (bit 0) of the newest stored entry. A push together with a pop on a full queue is accepted.
- R8: Status bit 10 is high while any stored receive entry has a nonzero flag. A pulse on `err_rd_i` clears the flags of the head entry. The bit falls only after an error read, a pop or a flush.
- R9: A transmit push into a full queue, a pop from an empty queue and an error read on an empty receive queue have no effect on counts, data or flags.
- R10: Both queues return their entries in push order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | Queues enabled (low: one-entry holding mode) |
| rx_rst_i | input | 1 | Receive flush pulse |
| tx_rst_i | input | 1 | Transmit flush pulse |
| rx_trig_i | input | 2 | Receive threshold code |
| tx_trig_i | input | 2 | Transmit threshold code |
| rx_push_i | input | 1 | Write a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 4 | Error flags of the received byte |
| rx_pop_i | input | 1 | Remove the head receive entry |
| err_rd_i | input | 1 | Error register read (clears head flags) |
| rx_data_o | output | 8 | Head receive byte |
| rx_err_o | output | 4 | Head receive error flags |
| tx_push_i | input | 1 | Write a byte to send |
| tx_data_i | input | 8 | Byte to send |
| tx_pop_i | input | 1 | Serializer takes the head byte |
| tx_data_o | output | 8 | Head transmit byte |
| stat_o | output | 11 | Status word |
| rx_irq_o | output | 1 | Receive threshold request |
| tx_irq_o | output | 1 | Transmit threshold request |

## Verification
The assertions check the following on every cycle: how the count field and full bit relate, that each flush empties its queue, that a dropped receive push holds the count and leaves an error pending, that a full transmit queue ignores pushes, that the pending flag falls only after a read, pop or flush, and that the request lines agree with empty and non-empty queues. The exact threshold per trigger code, the order of bytes and flags, and the overrun landing on the newest entry need a reference queue. Only the bench scenarios can show those, by driving fill sequences, sweeping the codes and draining with error reads. The same applies to the holding-register mode.

// File: rtl/uf_pkg.sv
package uf_pkg;
  localparam int unsigned ERR_W = 4;
  typedef struct packed {
    logic brk;
    logic frame;
    logic parity;
    logic ovr;
  } err_flags_t;
endpackage

// File: rtl/uf_fifo_core.sv
module uf_fifo_core #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          one_deep_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o
);
  localparam logic [CW-1:0] CAP_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, cap;

  assign cap       = one_deep_i ? CW'(1) : CAP_MAX;
  assign full_o    = cnt_q >= cap;
  assign pop_ok_o  = pop_i && (cnt_q != '0) && !flush_i;
  assign push_ok_o = push_i && (!full_o || pop_ok_o) && !flush_i;

  always_ff @(posedge clk_i) begin
    if (push_ok_o) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok_o) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok_o)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (push_ok_o && !pop_ok_o)      cnt_q <= cnt_q + 1'b1;
      else if (pop_ok_o && !push_ok_o) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdata_o  = mem_q[rd_q];
  assign cnt_o    = cnt_q;
  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
endmodule

// File: rtl/uf_err_track.sv
module uf_err_track
  import uf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       push_ok_i,
  input  logic       pop_ok_i,
  input  logic       ovr_i,
  input  logic       err_rd_i,
  input  logic       nonempty_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [AW-1:0] rd_ptr_i,
  input  err_flags_t err_i,
  output err_flags_t head_err_o,
  output logic       pend_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  err_flags_t    flags_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [AW-1:0] newest;

  assign newest = (wr_ptr_i == '0) ? LAST : wr_ptr_i - 1'b1;

  // later statements win: push over pop on a shared slot, overrun over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= '0;
    end else begin
      if (pop_ok_i) vld_q[rd_ptr_i] <= 1'b0;
      if (err_rd_i && nonempty_i) flags_q[rd_ptr_i] <= '0;
      if (push_ok_i) begin
        vld_q[wr_ptr_i]   <= 1'b1;
        flags_q[wr_ptr_i] <= err_i;
      end
      if (ovr_i && nonempty_i) flags_q[newest].ovr <= 1'b1;
    end
  end

  always_comb begin
    pend_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) pend_o |= vld_q[i] && (flags_q[i] != '0);
  end

  assign head_err_o = nonempty_i ? flags_q[rd_ptr_i] : '0;
endmodule

// File: rtl/uf_trig.sv
module uf_trig #(
  parameter int unsigned DEPTH = 16,
  parameter bit          IS_RX = 1'b1,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned LW   = CW + 2,
  localparam int unsigned STEP = DEPTH / 4
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    code_i,
  input  logic          en_i,
  output logic          irq_o
);
  logic [LW-1:0] lvl;
  logic [LW-1:0] cnt_x;

  assign cnt_x = LW'(cnt_i);

  generate
    if (IS_RX) begin : g_rx
      assign lvl   = en_i ? (LW'(code_i) + 1'b1) * LW'(STEP) : LW'(1);
      assign irq_o = cnt_x >= lvl;
    end else begin : g_tx
      assign lvl   = en_i ? LW'(code_i) * LW'(STEP) : '0;
      assign irq_o = cnt_x <= lvl;
    end
  endgenerate
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1,
  localparam int unsigned SW   = 2 * AW + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             rx_rst_i,
  input  logic             tx_rst_i,
  input  logic [1:0]       rx_trig_i,
  input  logic [1:0]       tx_trig_i,
  input  logic             rx_push_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic [ERR_W-1:0] rx_err_i,
  input  logic             rx_pop_i,
  input  logic             err_rd_i,
  output logic [DW-1:0]    rx_data_o,
  output logic [ERR_W-1:0] rx_err_o,
  input  logic             tx_push_i,
  input  logic [DW-1:0]    tx_data_i,
  input  logic             tx_pop_i,
  output logic [DW-1:0]    tx_data_o,
  output logic [SW-1:0]    stat_o,
  output logic             rx_irq_o,
  output logic             tx_irq_o
);
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_full, tx_full, rx_push_ok, rx_pop_ok, tx_push_ok, tx_pop_ok;
  logic [AW-1:0] rx_wr, rx_rd, tx_wr, tx_rd;
  logic          pend;
  err_flags_t    head_err;
  logic          unused_tx;

  uf_fifo_core #(.W(DW), .DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni, .flush_i(rx_rst_i), .one_deep_i(!fifo_en_i),
    .push_i(rx_push_i), .pop_i(rx_pop_i), .wdata_i(rx_data_i),
    .rdata_o(rx_data_o), .cnt_o(rx_cnt), .full_o(rx_full),
    .push_ok_o(rx_push_ok), .pop_ok_o(rx_pop_ok),
    .wr_ptr_o(rx_wr), .rd_ptr_o(rx_rd)
  );

  uf_err_track #(.DEPTH(DEPTH)) u_err (
    .clk_i, .rst_ni, .flush_i(rx_rst_i),
    .push_ok_i(rx_push_ok), .pop_ok_i(rx_pop_ok),
    .ovr_i(rx_push_i && !rx_push_ok && !rx_rst_i),
    .err_rd_i, .nonempty_i(rx_cnt != '0),
    .wr_ptr_i(rx_wr), .rd_ptr_i(rx_rd),
    .err_i(err_flags_t'(rx_err_i)), .head_err_o(head_err), .pend_o(pend)
  );

  uf_fifo_core #(.W(DW), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni, .flush_i(tx_rst_i), .one_deep_i(!fifo_en_i),
    .push_i(tx_push_i), .pop_i(tx_pop_i), .wdata_i(tx_data_i),
    .rdata_o(tx_data_o), .cnt_o(tx_cnt), .full_o(tx_full),
    .push_ok_o(tx_push_ok), .pop_ok_o(tx_pop_ok),
    .wr_ptr_o(tx_wr), .rd_ptr_o(tx_rd)
  );

  assign unused_tx = ^{tx_push_ok, tx_pop_ok, tx_wr, tx_rd};

  uf_trig #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_trig (
    .cnt_i(rx_cnt), .code_i(rx_trig_i), .en_i(fifo_en_i), .irq_o(rx_irq_o)
  );

  uf_trig #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_trig (
    .cnt_i(tx_cnt), .code_i(tx_trig_i), .en_i(fifo_en_i), .irq_o(tx_irq_o)
  );

  assign rx_err_o = head_err;
  assign stat_o   = {pend, tx_full, rx_full, tx_cnt[AW-1:0], rx_cnt[AW-1:0]};
endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned SW   = 2 * AW + 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          rx_rst_i,
  input logic          tx_rst_i,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic          err_rd_i,
  input logic          tx_push_i,
  input logic          tx_pop_i,
  input logic [SW-1:0] stat_o,
  input logic          rx_irq_o,
  input logic          tx_irq_o
);
  logic [AW-1:0] rxc, txc;
  logic          rxf, txf, pnd;
  assign rxc = stat_o[AW-1:0];
  assign txc = stat_o[2*AW-1:AW];
  assign rxf = stat_o[2*AW];
  assign txf = stat_o[2*AW+1];
  assign pnd = stat_o[2*AW+2];

  // R1
  full_cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && rxf) |-> (rxc == '0));

  // R5
  rx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_i |=> (rxc == '0 && !rxf && !pnd));

  // R5
  tx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_i |=> (txc == '0 && !txf));

  // R7
  rx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i && !rx_rst_i && rxf) |=> (rxc == $past(rxc) && pnd));

  // R9
  tx_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && !tx_pop_i && !tx_rst_i && txf) |=> (txc == $past(txc)));

  // R8
  pend_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pnd) |-> $past(err_rd_i || rx_pop_i || rx_rst_i));

  // R2
  rx_irq_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> (rxc != '0 || rxf));

  // R3
  tx_irq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txc == '0 && !txf) |-> tx_irq_o);
endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fifo_en_i(fifo_en_i),
  .rx_rst_i(rx_rst_i), .tx_rst_i(tx_rst_i), .rx_push_i(rx_push_i),
  .rx_pop_i(rx_pop_i), .err_rd_i(err_rd_i), .tx_push_i(tx_push_i),
  .tx_pop_i(tx_pop_i), .stat_o(stat_o), .rx_irq_o(rx_irq_o), .tx_irq_o(tx_irq_o)
);

// File: tb/sim_uart_fifo_pair.sv
module sim_uart_fifo_pair;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, rx_rst = 0, tx_rst = 0;
  logic [1:0] rx_trig = 0, tx_trig = 0;
  logic rx_push = 0, rx_pop = 0, err_rd = 0, tx_push = 0, tx_pop = 0;
  logic [7:0] rx_din = 0, tx_din = 0, rx_dout, tx_dout;
  logic [3:0] rx_ein = 0, rx_eout;
  logic [10:0] stat;
  logic rx_irq, tx_irq;

  int errors = 0, checks = 0;
  bit [7:0] dq[$];
  bit [3:0] eq[$];
  bit [7:0] tq[$];

  always #(CLK_NS/2) clk = ~clk;

  uart_fifo_pair u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .rx_rst_i(rx_rst),
    .tx_rst_i(tx_rst), .rx_trig_i(rx_trig), .tx_trig_i(tx_trig),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_err_i(rx_ein),
    .rx_pop_i(rx_pop), .err_rd_i(err_rd), .rx_data_o(rx_dout),
    .rx_err_o(rx_eout), .tx_push_i(tx_push), .tx_data_i(tx_din),
    .tx_pop_i(tx_pop), .tx_data_o(tx_dout), .stat_o(stat),
    .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int cap();
    return fifo_en ? 16 : 1;
  endfunction

  // compare every port against the reference queues
  task automatic check_all(string req);
    int rxc = dq.size(), txc = tq.size();
    bit pend = 0;
    int rx_lvl = fifo_en ? 4 * (int'(rx_trig) + 1) : 1;
    int tx_lvl = fifo_en ? 4 * int'(tx_trig) : 0;
    foreach (eq[i]) if (eq[i] != 0) pend = 1;
    chk(req, "stat", int'(stat),
        (int'(pend) << 10) | (int'(txc >= cap()) << 9) | (int'(rxc >= cap()) << 8)
        | ((txc % 16) << 4) | (rxc % 16));
    chk(req, "rx_irq", int'(rx_irq), int'(rxc >= rx_lvl));
    chk(req, "tx_irq", int'(tx_irq), int'(txc <= tx_lvl));
    chk(req, "rx_err_o", int'(rx_eout), rxc > 0 ? int'(eq[0]) : 0);
    if (rxc > 0) chk(req, "rx_data_o", int'(rx_dout), int'(dq[0]));
    if (txc > 0) chk(req, "tx_data_o", int'(tx_dout), int'(tq[0]));
  endtask

  // one cycle of stimulus; monitor compares popped items against the queues
  task automatic step(string req, bit rp, bit [7:0] rd, bit [3:0] re, bit rpop,
                      bit erd, bit tp, bit [7:0] td, bit tpop, bit rf, bit tf);
    bit pop_ok, push_ok, tpop_ok, tpush_ok;
    rx_push = rp; rx_din = rd; rx_ein = re; rx_pop = rpop; err_rd = erd;
    tx_push = tp; tx_din = td; tx_pop = tpop; rx_rst = rf; tx_rst = tf;
    if (rf) begin
      dq.delete(); eq.delete();
    end else begin
      pop_ok = rpop && dq.size() > 0;
      if (pop_ok) begin
        chk(req, "popped rx byte", int'(rx_dout), int'(dq[0]));
        chk(req, "popped rx flags", int'(rx_eout), int'(eq[0]));
      end
      if (erd && dq.size() > 0) eq[0] = 0;
      push_ok = rp && (dq.size() < cap() || pop_ok);
      if (pop_ok) begin
        void'(dq.pop_front()); void'(eq.pop_front());
      end
      if (rp && !push_ok && dq.size() > 0) eq[eq.size()-1] |= 4'b0001;
      if (push_ok) begin
        dq.push_back(rd); eq.push_back(re);
      end
    end
    if (tf) tq.delete();
    else begin
      tpop_ok = tpop && tq.size() > 0;
      if (tpop_ok) chk(req, "popped tx byte", int'(tx_dout), int'(tq[0]));
      tpush_ok = tp && (tq.size() < cap() || tpop_ok);
      if (tpop_ok) void'(tq.pop_front());
      if (tpush_ok) tq.push_back(td);
    end
    @(posedge clk); #1;
    rx_push = 0; rx_pop = 0; err_rd = 0; tx_push = 0; tx_pop = 0;
    rx_rst = 0; tx_rst = 0;
    check_all(req);
  endtask

  task automatic rxp(string req, bit [7:0] d, bit [3:0] e);
    step(req, 1, d, e, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    check_all("R1");

    // R6 flags stored with the byte, R2 threshold 4
    rxp("R6", 8'h11, 4'b0000);
    rxp("R6", 8'h22, 4'b0010);
    rxp("R2", 8'h33, 4'b0000);
    rxp("R2", 8'h44, 4'b0100);
    rx_trig = 1; #1 check_all("R2");
    rx_trig = 2; #1 check_all("R2");
    for (int i = 0; i < 12; i++) rxp("R1", 8'h50 + 8'(i), (i == 5) ? 4'b1000 : 4'b0000);
    rx_trig = 3; #1 check_all("R2");
    // R7 overrun on newest entry
    rxp("R7", 8'hEE, 4'b0000);
    step("R7", 1, 8'hEF, 4'b0000, 1, 0, 0, 0, 0, 0, 0);
    rx_trig = 0; #1 check_all("R2");
    // R8 drain with error reads
    while (dq.size() > 0) begin
      if (eq[0] != 0) step("R8", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      step("R10", 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    end
    step("R9", 0, 0, 0, 1, 1, 0, 0, 1, 0, 0);

    // R3 transmit thresholds
    tx_trig = 1;
    for (int i = 0; i < 5; i++) step("R3", 0, 0, 0, 0, 0, 1, 8'hA0 + 8'(i), 0, 0, 0);
    tx_trig = 2; #1 check_all("R3");
    tx_trig = 3; #1 check_all("R3");
    for (int i = 0; i < 13; i++) step("R9", 0, 0, 0, 0, 0, 1, 8'hC0 + 8'(i), 0, 0, 0);
    while (tq.size() > 0) step("R10", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    tx_trig = 0; #1 check_all("R3");

    // R5 flush beats a same-cycle push
    rxp("R5", 8'h01, 4'b0100);
    rxp("R5", 8'h02, 4'b0000);
    step("R5", 0, 0, 0, 0, 0, 1, 8'h03, 0, 0, 0);
    step("R5", 1, 8'h04, 4'b0010, 0, 0, 1, 8'h05, 0, 1, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 8'h06, 0, 0, 1);

    // R4 holding-register mode
    fifo_en = 0; #1 check_all("R4");
    rxp("R4", 8'h55, 4'b0000);
    rxp("R7", 8'h66, 4'b0000);
    step("R4", 0, 0, 0, 0, 0, 1, 8'h77, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 8'h78, 0, 0, 0);
    step("R8", 1, 8'h67, 4'b0000, 0, 1, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule